// File: doc/BRIEF.md
# Configurable Rate-1/2 Convolutional Encoder

This block encodes a stream of single bits with a rate-1/2 convolutional code of constraint length 7. It is meant for generating test signals. Each accepted input bit is combined with the six bits accepted before it, using two generator polynomials. The result is a pair of code symbols, which appears one clock later as a two-bit word. In serial mode the block also sends the two symbols out one after the other on a one-bit output. It holds its input-ready signal low for one cycle so that the output keeps up with the input.

Static configuration inputs control the symbol order and the inversion of each symbol. One input selects whether the first generator's symbol or the second generator's symbol leads each pair. Two more inputs invert each generator's symbol independently. The configuration is taken in the cycle in which a bit is accepted. A synchronous clear empties the history of past bits and drops any pending output. This lets a new code sequence start from the all-zero state.

Top module: `conv_encoder_r12`

## Requirements
- R1: Each accepted bit b forms a 7-bit window w = {b, h5..h0}, where h5 is the bit accepted just before b and h0 is the bit accepted six acceptances earlier. Symbol A is the XOR of w masked with 1111001 (octal 171), and symbol B is the XOR of w masked with 1011011 (octal 133). Window bit 6 is the current bit.
- R2: If a bit is accepted at a clock edge, `pair_valid` is high for the following cycle and `pair_out` holds that bit's pair. When no bit is accepted, `pair_valid` is low the next cycle and `pair_out` keeps its value.
- R3: With `b_first`=0, `pair_out[1]` is symbol A and `pair_out[0]` is symbol B. With `b_first`=1 the two swap.
- R4: With `inv_a`=1, symbol A is inverted before it is placed in the pair.
- R5: With `inv_b`=1, symbol B is inverted. This is independent of `inv_a`.
- R6: Asynchronous active-low reset clears the history to zero and drives `pair_valid`, `pair_out`, `ser_valid` and `ser_bit` to zero.
- R7: A synchronous `clr` clears the history to zero and drops `pair_valid` and `ser_valid` in the next cycle. No bit is accepted in a clearing cycle.
- R8: In serial mode (`serial_en`=1), a bit accepted at edge T has its first pair symbol on `ser_bit` with `ser_valid` high in cycle T+1, and its second symbol in cycle T+2. `in_ready` is low during cycle T+1.
- R9: A bit offered while `in_valid` or `in_ready` is low is not accepted and does not enter the history.
- R10: With `serial_en`=0, `in_ready` stays high and `ser_valid` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr | input | 1 | Synchronous clear of history and pending output |
| serial_en | input | 1 | Enables serialized symbol output |
| b_first | input | 1 | Places symbol B ahead of symbol A |
| inv_a | input | 1 | Inverts symbol A |
| inv_b | input | 1 | Inverts symbol B |
| in_valid | input | 1 | Input bit offered |
| in_bit | input | 1 | Data bit to encode |
| in_ready | output | 1 | Block can accept a bit this cycle |
| pair_valid | output | 1 | `pair_out` carries a fresh pair |
| pair_out | output | 2 | Code pair, bit 1 leads |
| ser_valid | output | 1 | `ser_bit` carries a symbol |
| ser_bit | output | 1 | Serialized code symbol |

## Verification
Some behaviours are checked by the in-module assertions on every cycle. These are the one-cycle link between acceptance and `pair_valid`, and the holding of `pair_out` when idle. They also cover the ready gap and the two-cycle symbol train in serial mode, and the emptying of the history after a clear. Other behaviours can only be shown by the bench's scenarios. These are the symbol values produced by the generator polynomials, the effect of order and inversion settings chosen at random per bit, and history that a refused offer must leave untouched. They are compared against an independent model of the code.

// File: rtl/conv_encoder_r12.sv
module conv_encoder_r12 #(
  parameter int CONSTR = 7,
  parameter logic [CONSTR-1:0] GEN_A = 7'o171,
  parameter logic [CONSTR-1:0] GEN_B = 7'o133
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       serial_en,
  input  logic       b_first,
  input  logic       inv_a,
  input  logic       inv_b,
  input  logic       in_valid,
  input  logic       in_bit,
  output logic       in_ready,
  output logic       pair_valid,
  output logic [1:0] pair_out,
  output logic       ser_valid,
  output logic       ser_bit
);
  localparam int HW = CONSTR - 1;

  logic [HW-1:0]     hist;
  logic [CONSTR-1:0] win;
  logic              sym_a, sym_b, lead, trail, acc, phase, trail_q;

  assign in_ready = !(serial_en && phase);
  assign acc      = in_valid && in_ready && !clr;
  assign win      = {in_bit, hist};
  assign sym_a    = (^(win & GEN_A)) ^ inv_a;
  assign sym_b    = (^(win & GEN_B)) ^ inv_b;
  assign lead     = b_first ? sym_b : sym_a;
  assign trail    = b_first ? sym_a : sym_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist       <= '0;
      pair_valid <= 1'b0;
      pair_out   <= 2'b00;
    end else if (clr) begin
      hist       <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= acc;
      if (acc) begin
        hist     <= win[CONSTR-1:1];
        pair_out <= {lead, trail};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= 1'b0;
      ser_valid <= 1'b0;
      ser_bit   <= 1'b0;
      trail_q   <= 1'b0;
    end else if (clr) begin
      phase     <= 1'b0;
      ser_valid <= 1'b0;
    end else if (phase) begin
      ser_bit   <= trail_q;
      ser_valid <= 1'b1;
      phase     <= 1'b0;
    end else if (acc && serial_en) begin
      ser_bit   <= lead;
      trail_q   <= trail;
      ser_valid <= 1'b1;
      phase     <= 1'b1;
    end else begin
      ser_valid <= 1'b0;
    end
  end

  AST_PAIR_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> pair_valid); // R2
  AST_PAIR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> !pair_valid && $stable(pair_out)); // R2
  AST_SER_GAP: assert property (@(posedge clk) disable iff (!rst_n) (acc && serial_en) |=> (!in_ready && ser_valid)); // R8
  AST_SER_TRAIL: assert property (@(posedge clk) disable iff (!rst_n) (ser_valid && !in_ready && !clr) |=> ser_valid); // R8
  AST_CLR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clr |=> (hist == '0 && !pair_valid && !ser_valid)); // R7
  AST_PAR_NO_SER: assert property (@(posedge clk) disable iff (!rst_n) (!serial_en && !phase) |=> !ser_valid); // R10
endmodule

// File: tb/tb_conv_encoder_r12.sv
module tb_conv_encoder_r12;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0, serial_en = 1'b0, b_first = 1'b0;
  logic inv_a = 1'b0, inv_b = 1'b0, in_valid = 1'b0, in_bit = 1'b0;
  logic in_ready, pair_valid, ser_valid, ser_bit;
  logic [1:0] pair_out;
  logic [5:0] mh = '0;
  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  conv_encoder_r12 dut (.clk(clk), .rst_n(rst_n), .clr(clr), .serial_en(serial_en), .b_first(b_first),
    .inv_a(inv_a), .inv_b(inv_b), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .pair_valid(pair_valid), .pair_out(pair_out), .ser_valid(ser_valid), .ser_bit(ser_bit));

  function automatic logic mask_xor(logic [6:0] w, logic [6:0] g);
    return ^(w & g);
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic push(logic b, logic sw, logic ia, logic ib, logic ser, logic hold);
    logic [6:0] w;
    logic sa, sb, f, s;
    @(negedge clk);
    serial_en = ser; b_first = sw; inv_a = ia; inv_b = ib;
    in_valid = 1'b1; in_bit = b;
    w  = {b, mh};
    sa = mask_xor(w, 7'b1111001) ^ ia;
    sb = mask_xor(w, 7'b1011011) ^ ib;
    f  = sw ? sb : sa;
    s  = sw ? sa : sb;
    mh = w[6:1];
    chk("R10/R8 ready before accept", {1'b0, in_ready}, 2'b01);
    @(negedge clk);
    in_valid = ser && hold;
    in_bit = $urandom_range(0, 1);
    chk("R2 pair_valid after accept", {1'b0, pair_valid}, 2'b01);
    chk("R1/R3/R4/R5 pair value", pair_out, {f, s});
    if (ser) begin
      chk("R8 first symbol and ready low", {ser_bit, in_ready}, {f, 1'b0});
      chk("R8 ser_valid first", {1'b0, ser_valid}, 2'b01);
      @(negedge clk);
      in_valid = 1'b0;
      chk("R9 offer while not ready ignored", {1'b0, pair_valid}, 2'b00);
      chk("R8 second symbol and ready back", {ser_bit, in_ready}, {s, 1'b1});
      chk("R8 ser_valid second", {1'b0, ser_valid}, 2'b01);
    end else begin
      chk("R10 no serial output", {ser_valid, in_ready}, 2'b01);
    end
  endtask

  task automatic idle_cycle();
    logic [1:0] prev;
    @(negedge clk);
    in_valid = 1'b0; in_bit = $urandom_range(0, 1);
    prev = pair_out;
    @(negedge clk);
    chk("R9 idle no pair", {1'b0, pair_valid}, 2'b00);
    chk("R2 pair held", pair_out, prev);
  endtask

  task automatic clear_hist();
    @(negedge clk);
    in_valid = 1'b1; in_bit = 1'b1; clr = 1'b1;
    @(negedge clk);
    clr = 1'b0; in_valid = 1'b0;
    mh = '0;
    chk("R7 clear drops valids", {pair_valid, ser_valid}, 2'b00);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_c0de));
    repeat (3) @(negedge clk);
    chk("R6 reset valids", {pair_valid, ser_valid}, 2'b00);
    chk("R6 reset pair", pair_out, 2'b00);
    chk("R6 reset ser_bit", {1'b0, ser_bit}, 2'b00);
    rst_n = 1'b1;
    push(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 6; i++) push(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    push(1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    push(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
    push(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
    push(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
    idle_cycle();
    clear_hist();
    push(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 400; i++) begin
      int r;
      r = $urandom_range(0, 19);
      if (r == 0) clear_hist();
      else if (r < 3) idle_cycle();
      else push($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1));
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule